// File: doc/BRIEF.md
# Byte and Halfword Load-Store Lane Unit

This block sits between a 32-bit register file and a 32-bit data memory that is addressed by word. For loads it takes the word fetched from memory, picks out the byte, halfword or full word named by the two low address bits, and widens the value to 32 bits with either sign extension or zero extension. For stores it copies the low byte or low halfword of the source register into every lane of the write word and raises only the byte-enable strobes of the lanes that are to be written. It also carries out the load-upper operation, which builds a constant in the upper half of the result and clears the lower half.

Lane numbering is big-endian. Byte offset 0 is bits 31..24 of the memory word, and byte offset 3 is bits 7..0. Strobe bit `k` of `byteEn` guards bits `8k+7..8k`. Consecutive words are 4 apart in the byte address, so only the two low address bits reach this block. An access that is not aligned to its own size is not carried out. The block raises a flag and drives no strobes, and it does not trap.

The operation code on `opSel` is 4 bits wide: 0 idle, 1 signed byte load, 2 unsigned byte load, 3 signed halfword load, 4 unsigned halfword load, 5 word load, 6 byte store, 7 halfword store, 8 word store, 9 load-upper. Codes 10 to 15 are treated as idle. The block is purely combinational.

Top module: `lane_unit`

## Requirements
- R1: The byte at offset o (o = `addrLow`) is taken from memory bits 31-8o..24-8o. The halfword at offset 0 is bits 31..16 and the halfword at offset 2 is bits 15..0.
- R2: A signed byte load (code 1) or signed halfword load (code 3) returns the selected value sign-extended to 32 bits.
- R3: An unsigned byte load (code 2) or unsigned halfword load (code 4) returns the selected value zero-extended to 32 bits.
- R4: A word load (code 5) at offset 0 returns the memory word unchanged.
- R5: The store write data is four copies of `regData[7:0]` for a byte store (code 6), two copies of `regData[15:0]` for a halfword store (code 7), and `regData` itself for a word store (code 8).
- R6: An aligned byte store drives the single strobe bit 3-o. An aligned halfword store drives `4'b1100` at offset 0 and `4'b0011` at offset 2. A word store drives `4'b1111`.
- R7: Load-upper (code 9) returns `{regData[15:0], 16'h0000}`; a constant of 61 gives 0x003D0000. It never flags misalignment.
- R8: A halfword access (codes 3, 4, 7) with address bit 0 set, or a word access (codes 5, 8) with any low address bit set, raises `misalign`, drives `byteEn` to 0 and returns 0 on `loadData`. A byte access never flags.
- R9: The load ops (codes 1 to 5 and 9), idle (code 0) and codes 10 to 15 drive `byteEn` = 0 and `memWdata` = 0. Idle and codes 10 to 15 also drive `loadData` = 0 and `misalign` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opSel | input | 4 | Operation code (see requirements) |
| addrLow | input | 2 | Low byte-address bits of the access |
| regData | input | 32 | Source register value for stores and load-upper |
| memRdata | input | 32 | Word read from data memory |
| memWdata | output | 32 | Lane-replicated store data |
| byteEn | output | 4 | Byte write strobes, bit 3 = bits 31..24 |
| loadData | output | 32 | Extended load result |
| misalign | output | 1 | Access not aligned to its size |

## Verification
The assertions are immediate and assume that `opSel` and `addrLow` hold defined values whenever the outputs are evaluated. They assume nothing else about the operation code, so the unused codes are covered as well. The bench drives every operation code at every one of the four offsets, with memory and register words chosen so that each byte has a different sign bit. It changes its inputs only on the falling clock edge, so each evaluated combination is complete and every input is a known value before any output is compared.

// File: rtl/lane_pkg.sv
package lane_pkg;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} accSize_e;

  localparam logic [3:0] OP_IDLE = 4'd0;
  localparam logic [3:0] OP_LBS  = 4'd1;
  localparam logic [3:0] OP_LBU  = 4'd2;
  localparam logic [3:0] OP_LHS  = 4'd3;
  localparam logic [3:0] OP_LHU  = 4'd4;
  localparam logic [3:0] OP_LW   = 4'd5;
  localparam logic [3:0] OP_SB   = 4'd6;
  localparam logic [3:0] OP_SH   = 4'd7;
  localparam logic [3:0] OP_SW   = 4'd8;
  localparam logic [3:0] OP_LUP  = 4'd9;

  typedef struct packed {
    logic     loadEn;
    logic     storeEn;
    logic     upperEn;
    logic     signedLd;
    logic     misalign;
    accSize_e accSize;
  } laneCtrl_t;
endpackage

// File: rtl/lane_ctrl.sv
module lane_ctrl
  import lane_pkg::*;
#(
  parameter int OP_W   = 4,
  parameter int ADDR_W = 2
) (
  input  logic [OP_W-1:0]   opSel,
  input  logic [ADDR_W-1:0] addrLow,
  output laneCtrl_t         ctrl
);
  laneCtrl_t dec;
  logic      badHalf;
  logic      badWord;

  always_comb begin
    dec = '0;
    dec.accSize = SZ_WORD;
    unique case (opSel)
      OP_LBS: begin dec.loadEn = 1'b1; dec.signedLd = 1'b1; dec.accSize = SZ_BYTE; end
      OP_LBU: begin dec.loadEn = 1'b1; dec.accSize = SZ_BYTE; end
      OP_LHS: begin dec.loadEn = 1'b1; dec.signedLd = 1'b1; dec.accSize = SZ_HALF; end
      OP_LHU: begin dec.loadEn = 1'b1; dec.accSize = SZ_HALF; end
      OP_LW:  begin dec.loadEn = 1'b1; end
      OP_SB:  begin dec.storeEn = 1'b1; dec.accSize = SZ_BYTE; end
      OP_SH:  begin dec.storeEn = 1'b1; dec.accSize = SZ_HALF; end
      OP_SW:  begin dec.storeEn = 1'b1; end
      OP_LUP: begin dec.upperEn = 1'b1; end
      default: ;
    endcase
  end

  assign badHalf = addrLow[0];
  assign badWord = |addrLow;

  always_comb begin
    ctrl = dec;
    ctrl.misalign = 1'b0;
    if (dec.loadEn || dec.storeEn) begin
      if (dec.accSize == SZ_HALF) ctrl.misalign = badHalf;
      else if (dec.accSize == SZ_WORD) ctrl.misalign = badWord;
    end
  end
endmodule

// File: rtl/lane_datapath.sv
module lane_datapath
  import lane_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int ADDR_W = 2
) (
  input  laneCtrl_t                 ctrl,
  input  logic [ADDR_W-1:0]         addrLow,
  input  logic [LANES*LANE_W-1:0]   regData,
  input  logic [LANES*LANE_W-1:0]   memRdata,
  output logic [LANES*LANE_W-1:0]   memWdata,
  output logic [LANES-1:0]          byteEn,
  output logic [LANES*LANE_W-1:0]   loadData
);
  localparam int WORD_W = LANES * LANE_W;
  localparam int HALF_W = WORD_W / 2;
  localparam int HALVES = 2;

  logic [LANE_W-1:0] pickByte;
  logic [HALF_W-1:0] pickHalf;
  int                byteIdx;
  int                halfIdx;

  // Big-endian: offset 0 is the top lane.
  assign byteIdx  = LANES - 1 - int'(addrLow);
  assign halfIdx  = HALVES - 1 - int'(addrLow[ADDR_W-1]);
  assign pickByte = memRdata[byteIdx*LANE_W +: LANE_W];
  assign pickHalf = memRdata[halfIdx*HALF_W +: HALF_W];

  always_comb begin
    loadData = '0;
    if (ctrl.upperEn) begin
      loadData = {regData[HALF_W-1:0], {HALF_W{1'b0}}};
    end else if (ctrl.loadEn && !ctrl.misalign) begin
      unique case (ctrl.accSize)
        SZ_BYTE: loadData = {{(WORD_W-LANE_W){ctrl.signedLd & pickByte[LANE_W-1]}}, pickByte};
        SZ_HALF: loadData = {{(WORD_W-HALF_W){ctrl.signedLd & pickHalf[HALF_W-1]}}, pickHalf};
        default: loadData = memRdata;
      endcase
    end
  end

  logic strobeOk;
  assign strobeOk = ctrl.storeEn && !ctrl.misalign;

  genvar gi;
  generate
    for (gi = 0; gi < LANES; gi++) begin : g_lane
      localparam int LANE_OFS  = LANES - 1 - gi;
      localparam int LANE_HALF = gi / (LANES / HALVES);
      logic hitByte, hitHalf;
      assign hitByte = (int'(addrLow) == LANE_OFS);
      assign hitHalf = (LANE_HALF == halfIdx);
      always_comb begin
        unique case (ctrl.accSize)
          SZ_BYTE: byteEn[gi] = strobeOk & hitByte;
          SZ_HALF: byteEn[gi] = strobeOk & hitHalf;
          default: byteEn[gi] = strobeOk;
        endcase
      end
      always_comb begin
        memWdata[gi*LANE_W +: LANE_W] = '0;
        if (ctrl.storeEn) begin
          unique case (ctrl.accSize)
            SZ_BYTE: memWdata[gi*LANE_W +: LANE_W] = regData[LANE_W-1:0];
            SZ_HALF: memWdata[gi*LANE_W +: LANE_W] =
                       regData[(gi % (LANES/HALVES))*LANE_W +: LANE_W];
            default: memWdata[gi*LANE_W +: LANE_W] = regData[gi*LANE_W +: LANE_W];
          endcase
        end
      end
    end
  endgenerate
endmodule

// File: rtl/lane_unit.sv
module lane_unit
  import lane_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int OP_W   = 4,
  localparam int ADDR_W = $clog2(LANES),
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic [OP_W-1:0]   opSel,
  input  logic [ADDR_W-1:0] addrLow,
  input  logic [WORD_W-1:0] regData,
  input  logic [WORD_W-1:0] memRdata,
  output logic [WORD_W-1:0] memWdata,
  output logic [LANES-1:0]  byteEn,
  output logic [WORD_W-1:0] loadData,
  output logic              misalign
);
  laneCtrl_t ctrl;

  lane_ctrl #(.OP_W(OP_W), .ADDR_W(ADDR_W)) u_ctrl (
    .opSel(opSel), .addrLow(addrLow), .ctrl(ctrl)
  );

  lane_datapath #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_dp (
    .ctrl(ctrl), .addrLow(addrLow), .regData(regData), .memRdata(memRdata),
    .memWdata(memWdata), .byteEn(byteEn), .loadData(loadData)
  );

  assign misalign = ctrl.misalign;
endmodule

// File: rtl/lane_unit_chk.sv
module lane_unit_chk (
  input logic [3:0]  opSel,
  input logic [1:0]  addrLow,
  input logic [31:0] regData,
  input logic [31:0] memWdata,
  input logic [3:0]  byteEn,
  input logic [31:0] loadData,
  input logic        misalign
);
  logic isStore;
  assign isStore = (opSel == 4'd6) || (opSel == 4'd7) || (opSel == 4'd8);

  always_comb begin
    a_r8_no_strobe_when_misaligned: assert (!misalign || byteEn == 4'b0000)
      else $error("R8 strobes active on misaligned access");
    a_r9_no_strobe_off_store: assert (isStore || byteEn == 4'b0000)
      else $error("R9 strobes active outside a store");
    a_r6_byte_store_onehot: assert (opSel != 4'd6 || $countones(byteEn) == 1)
      else $error("R6 byte store strobe count");
    a_r6_half_store_pair: assert (opSel != 4'd7 || misalign || $countones(byteEn) == 2)
      else $error("R6 halfword store strobe count");
    a_r7_upper_low_clear: assert (opSel != 4'd9 || (loadData[15:0] == 16'h0 && !misalign))
      else $error("R7 load-upper low half not clear");
    a_r5_byte_replicated: assert (opSel != 4'd6 || memWdata == {4{regData[7:0]}})
      else $error("R5 byte store data not replicated");
    a_r2_byte_sign: assert (opSel != 4'd1 || loadData[31:8] == {24{loadData[7]}})
      else $error("R2 signed byte load not sign-extended");
    a_r3_byte_zero: assert (opSel != 4'd2 || loadData[31:8] == 24'h0)
      else $error("R3 unsigned byte load not zero-extended");
  end
endmodule

bind lane_unit lane_unit_chk u_chk (
  .opSel(opSel), .addrLow(addrLow), .regData(regData), .memWdata(memWdata),
  .byteEn(byteEn), .loadData(loadData), .misalign(misalign)
);

// File: tb/sim_lane_unit.sv
module sim_lane_unit;
  logic        clk = 1'b0;
  logic [3:0]  opSel = 4'd0;
  logic [1:0]  addrLow = 2'd0;
  logic [31:0] regData = 32'h0;
  logic [31:0] memRdata = 32'h0;
  logic [31:0] memWdata;
  logic [3:0]  byteEn;
  logic [31:0] loadData;
  logic        misalign;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lane_unit u0 (
    .opSel(opSel), .addrLow(addrLow), .regData(regData), .memRdata(memRdata),
    .memWdata(memWdata), .byteEn(byteEn), .loadData(loadData), .misalign(misalign)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h (op %0d ofs %0d)", tag, what, act, exp, opSel, addrLow);
    end
  endtask

  task automatic drive(input logic [3:0] op, input logic [1:0] ofs, input logic [31:0] rd, input logic [31:0] mr);
    @(negedge clk);
    opSel = op; addrLow = ofs; regData = rd; memRdata = mr;
    #1;
  endtask

  // Expected values derived arithmetically from the requirements.
  task automatic sweepOne(input int op, input int ofs, input logic [31:0] rd, input logic [31:0] mr);
    logic [31:0] eLoad, eWd; logic [3:0] eEn; logic eMis;
    logic [7:0] b; logic [15:0] h;
    string lt, et, wt;
    b = 8'((mr >> (8 * (3 - ofs))) & 32'hFF);
    h = 16'((mr >> (16 * (1 - ofs / 2))) & 32'hFFFF);
    eMis = ((op == 3 || op == 4 || op == 7) && (ofs % 2) != 0) ||
           ((op == 5 || op == 8) && ofs != 0);
    eLoad = 32'h0; eWd = 32'h0; eEn = 4'h0;
    lt = "R9"; et = "R9"; wt = "R9";
    case (op)
      1: begin lt = "R2"; eLoad = 32'(signed'(b)); end
      2: begin lt = "R3"; eLoad = {24'h0, b}; end
      3: begin lt = "R2"; if (!eMis) eLoad = 32'(signed'(h)); end
      4: begin lt = "R3"; if (!eMis) eLoad = {16'h0, h}; end
      5: begin lt = "R4"; if (!eMis) eLoad = mr; end
      6: begin et = "R6"; wt = "R5"; eWd = rd[7:0] * 32'h01010101; eEn = 4'(1 << (3 - ofs)); end
      7: begin et = "R6"; wt = "R5"; eWd = rd[15:0] * 32'h00010001;
                if (!eMis) eEn = (ofs == 0) ? 4'b1100 : 4'b0011; end
      8: begin et = "R6"; wt = "R5"; eWd = rd; if (!eMis) eEn = 4'b1111; end
      9: begin lt = "R7"; eLoad = rd[15:0] * 32'h10000; end
      default: ;
    endcase
    if (eMis) begin lt = "R8"; et = "R8"; end
    drive(4'(op), 2'(ofs), rd, mr);
    check(lt, "loadData", loadData, eLoad);
    check(et, "byteEn", {28'h0, byteEn}, {28'h0, eEn});
    check(wt, "memWdata", memWdata, eWd);
    check("R8", "misalign", {31'h0, misalign}, {31'h0, eMis});
  endtask

  initial begin
    logic [31:0] mPat [4];
    logic [31:0] rPat [4];
    mPat[0] = 32'h80FF7F01; mPat[1] = 32'h12345678; mPat[2] = 32'hFEDCBA98; mPat[3] = 32'h7F80017E;
    rPat[0] = 32'hA5C3E781; rPat[1] = 32'h0000003D; rPat[2] = 32'h55AA7F80; rPat[3] = 32'hFFFFFFFF;

    // Idle state at start (R9)
    drive(4'd0, 2'd0, 32'h0, 32'h0);
    check("R9", "idle loadData", loadData, 32'h0);
    check("R9", "idle byteEn", {28'h0, byteEn}, 32'h0);

    // Directed corner cases
    drive(4'd2, 2'd0, 32'h0, 32'h12345678);
    check("R1", "offset0 byte is MSB", loadData, 32'h00000012);
    drive(4'd2, 2'd3, 32'h0, 32'h12345678);
    check("R1", "offset3 byte is LSB", loadData, 32'h00000078);
    drive(4'd4, 2'd2, 32'h0, 32'h12345678);
    check("R1", "offset2 half is low half", loadData, 32'h00005678);
    drive(4'd9, 2'd1, 32'h0000003D, 32'h0);
    check("R7", "load-upper of 61", loadData, 32'h003D0000);
    check("R7", "load-upper no flag", {31'h0, misalign}, 32'h0);
    drive(4'd1, 2'd1, 32'h0, 32'h0080FFFF);
    check("R2", "signed byte 0x80", loadData, 32'hFFFFFF80);
    drive(4'd8, 2'd2, 32'hDEADBEEF, 32'h0);
    check("R8", "word store misaligned strobes", {28'h0, byteEn}, 32'h0);

    // Exhaustive sweep of codes, offsets and data patterns
    for (int op = 0; op < 16; op++)
      for (int ofs = 0; ofs < 4; ofs++)
        for (int p = 0; p < 4; p++)
          sweepOne(op, ofs, rPat[p], mPat[p]);

    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule